// File: doc/BRIEF.md
# Shared Multi-Core Interrupt Router

The router collects a parameterised set of shared external interrupt sources and delivers each one to a chosen output pin on any subset of processor cores. Every source carries its own polarity, trigger type (level or edge), mask bit, pending bit and routing. A source may also be sent to a per-core non-maskable output instead of a numbered pin. Software configures the block through a simple 32-bit register port. It can raise or drop any source through a single write-only "software trigger" register, and it can read the source and core counts from a read-only configuration word.

Each core receives a vector of pin outputs and an NMI output. When the `EIC_EN` parameter is set, each core also receives an encoded code: the pin number of its lowest-numbered visible source, plus one, so that zero means nothing is pending. Interrupt inputs are sampled into the pending state on one clock edge. The outputs are a combinational function of the pending, mask and routing state.

The register port is run by a three-state machine. `BUS_IDLE` accepts a request. The transition *accept-read* goes to `BUS_RD_ACK`, and *accept-write* goes to `BUS_WR_ACK`. Both acknowledge states return to `BUS_IDLE` unconditionally on the next edge through the transition *complete*.

Top module: `irq_router`

## Requirements
- R1: After reset every source is active-high (polarity word reads all ones for implemented sources), level-triggered (trigger word reads 0), masked (mask word reads 0), unrouted (map words read 0), and all pin, NMI and code outputs are 0.
- R2: A read of byte address 0x000 returns the source count as field N in bits [23:16] meaning (N+1)*8 sources, and the core count as field M in bits [7:0] meaning M+1 cores; other bits read 0.
- R3: A write to 0x004 with bit 31 set raises the source whose index is in bits [7:0]. The same write with bit 31 clear drops it. The effect is visible in the pending word read right after the write.
- R4: A level source is pending one clock edge after its input equals the active value, and stops being pending one edge after it no longer does. Polarity bit 1 (words at 0x140 + 4*w, bit s%32) means active-high; bit 0 means active-low.
- R5: An edge source (trigger bit 1, words at 0x180 + 4*w) latches pending on its inactive-to-active transition and holds it after the input returns. It is cleared by a software-trigger clear or by writing 1 to its bit in the pending word (0x040 + 4*w). Such a write has no effect on a level source.
- R6: Writing ones to the set-mask word (0x0C0 + 4*w) sets those mask bits. Writing ones to the clear-mask word (0x100 + 4*w) clears them. Zero bits leave the mask unchanged. The mask reads back at 0x080 + 4*w.
- R7: A core sees a source only when the source is pending, its mask bit is 1, and its bit for that core in the core-map word (0x800 + 4*s, bit c) is 1.
- R8: The pin-map word (0x400 + 4*s) routes a visible source to pin bits[PIN_W-1:0] of each selected core when bit 31 is set. Core c's pin p is `irq_pin[c*NUM_PIN + p]`.
- R9: When bit 30 of the pin-map word is set, a visible source drives `nmi[c]` of every selected core instead of any pin, and it is left out of the encoded code.
- R10: With `EIC_EN`, `eic_code[c*CODE_W +: CODE_W]` equals the pin number plus one of the lowest-indexed source that is visible to core c and routed to a pin, or 0 when there is none.
- R11: `ack` is high for exactly the one cycle after an accepted request. `rdata` is valid in that cycle. A write-only register (0x004, 0x0C0, 0x100) reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Shared interrupt source inputs |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access acknowledge, one cycle |
| rdata | output | 32 | Read data, valid with ack |
| irq_pin | output | NUM_CORE*NUM_PIN | Per-core interrupt pins |
| nmi | output | NUM_CORE | Per-core non-maskable interrupt |
| eic_code | output | NUM_CORE*CODE_W | Per-core encoded pin number plus one |

## Verification
A register write lands on the edge that accepts the request. Mask and routing changes therefore reach the pin, NMI and code outputs as soon as that edge has passed. A change of an interrupt input or of a polarity bit reaches the outputs one edge later, because the active value is registered. Read data and `ack` appear in the cycle after the accepting edge. The bench drives on falling edges. After an input change it waits exactly one rising edge before sampling. Every access task ends one rising edge after the acknowledge, so results that depend on the polarity register have already settled when they are read.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_RD_ACK = 2'd1,
        BUS_WR_ACK = 2'd2
    } bus_state_e;

    // 64-byte regions in the low kilobyte, selected by addr[11:6]
    localparam logic [5:0] RG_CTRL = 6'h00;
    localparam logic [5:0] RG_PEND = 6'h01;
    localparam logic [5:0] RG_MASK = 6'h02;
    localparam logic [5:0] RG_SETM = 6'h03;
    localparam logic [5:0] RG_CLRM = 6'h04;
    localparam logic [5:0] RG_POL  = 6'h05;
    localparam logic [5:0] RG_TRIG = 6'h06;

    // per-source map tables selected by addr[11:10]
    localparam logic [1:0] TB_PIN  = 2'b01;
    localparam logic [1:0] TB_CORE = 2'b10;

    localparam logic [11:0] ADDR_CFG   = 12'h000;
    localparam logic [11:0] ADDR_SWTRG = 12'h004;

    localparam int SWTRG_RAISE = 31;
    localparam int MAP_PIN_EN  = 31;
    localparam int MAP_NMI     = 30;
    localparam int PAD_BITS    = 512;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int PIN_W    = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req,
    input  logic                               we,
    input  logic [11:0]                        addr,
    input  logic [31:0]                        wdata,
    output logic                               ack,
    output logic [31:0]                        rdata,
    input  logic [NUM_SRC-1:0]                 pend_i,
    output logic [NUM_SRC-1:0]                 pol_o,
    output logic [NUM_SRC-1:0]                 trig_o,
    output logic [NUM_SRC-1:0]                 mask_o,
    output logic [NUM_SRC-1:0]                 pin_en_o,
    output logic [NUM_SRC-1:0]                 nmi_o,
    output logic [NUM_SRC-1:0][PIN_W-1:0]      pin_o,
    output logic [NUM_SRC-1:0][NUM_CORE-1:0]   core_o,
    output logic [NUM_SRC-1:0]                 swset_o,
    output logic [NUM_SRC-1:0]                 swclr_o,
    output logic [NUM_SRC-1:0]                 w1c_o
);

    localparam int SIDX_W = $clog2(NUM_SRC);
    localparam logic [7:0] SRC_FIELD  = 8'(NUM_SRC / 8 - 1);
    localparam logic [7:0] CORE_FIELD = 8'(NUM_CORE - 1);

    bus_state_e state_q, state_d;
    logic [31:0] rdata_q;
    logic [31:0] rd_mux;
    logic        accept, wr, rd;
    logic [5:0]  region;
    logic [1:0]  table_sel;
    logic [8:0]  word_base;
    logic        map_in_range;
    logic [SIDX_W-1:0] sidx;
    logic [PAD_BITS-1:0] pend_pad, mask_pad, pol_pad, trig_pad;

    assign accept       = (state_q == BUS_IDLE) && req;
    assign wr           = accept && we;
    assign rd           = accept && !we;
    assign region       = addr[11:6];
    assign table_sel    = addr[11:10];
    assign word_base    = {addr[5:2], 5'd0};
    assign map_in_range = (int'(addr[9:2]) < NUM_SRC);
    assign sidx         = addr[2 +: SIDX_W];

    assign pend_pad = PAD_BITS'(pend_i);
    assign mask_pad = PAD_BITS'(mask_o);
    assign pol_pad  = PAD_BITS'(pol_o);
    assign trig_pad = PAD_BITS'(trig_o);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept-read, accept-write, complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (req) state_d = we ? BUS_WR_ACK : BUS_RD_ACK;
            BUS_RD_ACK: state_d = BUS_IDLE;
            BUS_WR_ACK: state_d = BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    // outputs of the port machine
    always_comb begin
        ack = 1'b0;
        unique case (state_q)
            BUS_IDLE:   ack = 1'b0;
            BUS_RD_ACK: ack = 1'b1;
            BUS_WR_ACK: ack = 1'b1;
            default:    ack = 1'b0;
        endcase
    end
    assign rdata = rdata_q;

    // read selection
    always_comb begin
        rd_mux = '0;
        if (table_sel == TB_PIN) begin
            if (map_in_range) begin
                rd_mux[MAP_PIN_EN]  = pin_en_o[sidx];
                rd_mux[MAP_NMI]     = nmi_o[sidx];
                rd_mux[PIN_W-1:0]   = pin_o[sidx];
            end
        end else if (table_sel == TB_CORE) begin
            if (map_in_range) rd_mux[NUM_CORE-1:0] = core_o[sidx];
        end else begin
            unique case (region)
                RG_PEND: rd_mux = pend_pad[word_base +: 32];
                RG_MASK: rd_mux = mask_pad[word_base +: 32];
                RG_POL:  rd_mux = pol_pad[word_base +: 32];
                RG_TRIG: rd_mux = trig_pad[word_base +: 32];
                RG_CTRL: if (addr == ADDR_CFG) rd_mux = {8'h00, SRC_FIELD, 8'h00, CORE_FIELD};
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
        else if (wr) rdata_q <= '0;
    end

    // per-source configuration storage
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int         BIT = s % 32;
        localparam logic [3:0] WRD = 4'(s / 32);
        localparam logic [7:0] SID = 8'(s);

        logic r_pol, r_trig, r_mask, r_pin_en, r_nmi;
        logic [PIN_W-1:0]    r_pin;
        logic [NUM_CORE-1:0] r_core;
        logic hit_word, hit_map, sw_hit;

        assign hit_word = (table_sel == 2'b00) && (addr[5:2] == WRD);
        assign hit_map  = (addr[9:2] == SID);
        assign sw_hit   = wr && (addr == ADDR_SWTRG) && (wdata[7:0] == SID);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_pol    <= 1'b1;
                r_trig   <= 1'b0;
                r_mask   <= 1'b0;
                r_pin_en <= 1'b0;
                r_nmi    <= 1'b0;
                r_pin    <= '0;
                r_core   <= '0;
            end else if (wr) begin
                if (hit_word && region == RG_POL)  r_pol  <= wdata[BIT];
                if (hit_word && region == RG_TRIG) r_trig <= wdata[BIT];
                if (hit_word && region == RG_SETM && wdata[BIT]) r_mask <= 1'b1;
                if (hit_word && region == RG_CLRM && wdata[BIT]) r_mask <= 1'b0;
                if (table_sel == TB_PIN && hit_map) begin
                    r_pin_en <= wdata[MAP_PIN_EN];
                    r_nmi    <= wdata[MAP_NMI];
                    r_pin    <= wdata[PIN_W-1:0];
                end
                if (table_sel == TB_CORE && hit_map) r_core <= wdata[NUM_CORE-1:0];
            end
        end

        assign pol_o[s]    = r_pol;
        assign trig_o[s]   = r_trig;
        assign mask_o[s]   = r_mask;
        assign pin_en_o[s] = r_pin_en;
        assign nmi_o[s]    = r_nmi;
        assign pin_o[s]    = r_pin;
        assign core_o[s]   = r_core;
        assign swset_o[s]  = sw_hit && wdata[SWTRG_RAISE];
        assign swclr_o[s]  = sw_hit && !wdata[SWTRG_RAISE];
        assign w1c_o[s]    = wr && hit_word && region == RG_PEND && wdata[BIT];
    end

    // R11: acknowledge is a single-cycle pulse
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R11: an accepted request is acknowledged on the next cycle
    p_req_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && req) |=> ack);

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0] swset,
    input  logic [NUM_SRC-1:0] swclr,
    input  logic [NUM_SRC-1:0] w1c,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
        logic act_now, act_q, sw_q, edge_q;

        assign act_now = pol[s] ? irq_in[s] : !irq_in[s];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q  <= 1'b0;
                sw_q   <= 1'b0;
                edge_q <= 1'b0;
            end else begin
                act_q <= act_now;
                if (swset[s])      sw_q <= 1'b1;
                else if (swclr[s]) sw_q <= 1'b0;
                if (!trig[s])                          edge_q <= 1'b0;
                else if (swset[s] || (act_now && !act_q)) edge_q <= 1'b1;
                else if (swclr[s] || w1c[s])           edge_q <= 1'b0;
            end
        end

        assign pend_o[s] = trig[s] ? edge_q : (act_q || sw_q);

        // R3: a software raise is pending on the next cycle
        p_swset_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
            swset[s] |=> pend_o[s]);

        // R5: a latched edge survives until an explicit clear
        p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[s] && edge_q && !swclr[s] && !w1c[s]) |=> edge_q);
    end

endmodule

// File: rtl/irq_core_sel.sv
module irq_core_sel #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 8,
    parameter int PIN_W    = 3,
    parameter int CODE_W   = 4,
    parameter int CORE_ID  = 0,
    parameter bit EIC_EN   = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               pend,
    input  logic [NUM_SRC-1:0]               mask,
    input  logic [NUM_SRC-1:0]               pin_en,
    input  logic [NUM_SRC-1:0]               nmi_f,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]    pin,
    input  logic [NUM_SRC-1:0][NUM_CORE-1:0] core_map,
    output logic [NUM_PIN-1:0]               pins_o,
    output logic                             nmi_o,
    output logic [CODE_W-1:0]                code_o
);

    logic [NUM_SRC-1:0] vis;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_vis
        assign vis[s] = pend[s] && mask[s] && core_map[s][CORE_ID];
    end

    always_comb begin
        pins_o = '0;
        nmi_o  = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (vis[s]) begin
                if (nmi_f[s])       nmi_o = 1'b1;
                else if (pin_en[s]) pins_o[pin[s]] = 1'b1;
            end
        end
    end

    if (EIC_EN) begin : g_eic
        logic [PIN_W-1:0] code_pin;

        always_comb begin
            code_o = '0;
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (vis[s] && !nmi_f[s] && pin_en[s])
                    code_o = CODE_W'(pin[s]) + CODE_W'(1);
            end
        end

        assign code_pin = PIN_W'(code_o - CODE_W'(1));

        // R10: a nonzero code always names a pin that is driven
        p_code_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (code_o != '0) |-> pins_o[code_pin]);
    end else begin : g_no_eic
        assign code_o = '0;
    end

    // R7: no pin is driven without a visible source for this core
    p_pins_vis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pins_o) |-> (|(pend & mask)));

    // R9: the NMI output needs a pending, unmasked source
    p_nmi_vis_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (|(pend & mask)));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 8,
    parameter bit EIC_EN   = 1'b1,
    localparam int PIN_W   = $clog2(NUM_PIN),
    localparam int CODE_W  = $clog2(NUM_PIN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           irq_in,
    input  logic                         req,
    input  logic                         we,
    input  logic [11:0]                  addr,
    input  logic [31:0]                  wdata,
    output logic                         ack,
    output logic [31:0]                  rdata,
    output logic [NUM_CORE*NUM_PIN-1:0]  irq_pin,
    output logic [NUM_CORE-1:0]          nmi,
    output logic [NUM_CORE*CODE_W-1:0]   eic_code
);

    logic [NUM_SRC-1:0] pend, pol, trig, mask, pin_en, nmi_f;
    logic [NUM_SRC-1:0] swset, swclr, w1c;
    logic [NUM_SRC-1:0][PIN_W-1:0]    pin;
    logic [NUM_SRC-1:0][NUM_CORE-1:0] core_map;

    irq_regfile #(
        .NUM_SRC (NUM_SRC),
        .NUM_CORE(NUM_CORE),
        .PIN_W   (PIN_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .ack     (ack),
        .rdata   (rdata),
        .pend_i  (pend),
        .pol_o   (pol),
        .trig_o  (trig),
        .mask_o  (mask),
        .pin_en_o(pin_en),
        .nmi_o   (nmi_f),
        .pin_o   (pin),
        .core_o  (core_map),
        .swset_o (swset),
        .swclr_o (swclr),
        .w1c_o   (w1c)
    );

    irq_pending #(
        .NUM_SRC(NUM_SRC)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_in(irq_in),
        .pol   (pol),
        .trig  (trig),
        .swset (swset),
        .swclr (swclr),
        .w1c   (w1c),
        .pend_o(pend)
    );

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        irq_core_sel #(
            .NUM_SRC (NUM_SRC),
            .NUM_CORE(NUM_CORE),
            .NUM_PIN (NUM_PIN),
            .PIN_W   (PIN_W),
            .CODE_W  (CODE_W),
            .CORE_ID (c),
            .EIC_EN  (EIC_EN)
        ) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend    (pend),
            .mask    (mask),
            .pin_en  (pin_en),
            .nmi_f   (nmi_f),
            .pin     (pin),
            .core_map(core_map),
            .pins_o  (irq_pin[c*NUM_PIN +: NUM_PIN]),
            .nmi_o   (nmi[c]),
            .code_o  (eic_code[c*CODE_W +: CODE_W])
        );
    end

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

    localparam int NUM_SRC  = 16;
    localparam int NUM_CORE = 2;
    localparam int NUM_PIN  = 8;
    localparam int CODE_W   = 4;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [NUM_SRC-1:0]          irq_in = '0;
    logic                        req = 1'b0;
    logic                        we = 1'b0;
    logic [11:0]                 addr = '0;
    logic [31:0]                 wdata = '0;
    logic                        ack;
    logic [31:0]                 rdata;
    logic [NUM_CORE*NUM_PIN-1:0] irq_pin;
    logic [NUM_CORE-1:0]         nmi;
    logic [NUM_CORE*CODE_W-1:0]  eic_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_router #(
        .NUM_SRC (NUM_SRC),
        .NUM_CORE(NUM_CORE),
        .NUM_PIN (NUM_PIN),
        .EIC_EN  (1'b1)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .req     (req),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .ack     (ack),
        .rdata   (rdata),
        .irq_pin (irq_pin),
        .nmi     (nmi),
        .eic_code(eic_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] q);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        q = rdata;
        req = 1'b0; we = 1'b0;
        @(posedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(1'b1, a, d, q);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] q;
        bus(1'b0, a, 32'h0, q);
        chk(tag, q, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 pins", 32'(irq_pin), 32'h0);
        chk("R1 nmi", 32'(nmi), 32'h0);
        chk("R1 code", 32'(eic_code), 32'h0);
        rd_chk("R1 mask", 12'h080, 32'h0);
        rd_chk("R1 pol", 12'h140, 32'h0000_FFFF);
        rd_chk("R1 trig", 12'h180, 32'h0);
        rd_chk("R1 pend", 12'h040, 32'h0);
        rd_chk("R1 pinmap", 12'h400, 32'h0);
    endtask

    task automatic t_port;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 12'h000;
        chk("R11 ack idle", 32'(ack), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R11 ack", 32'(ack), 32'h1);
        chk("R2 config", rdata, 32'h0001_0001);
        req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11 ack drop", 32'(ack), 32'h0);
        rd_chk("R11 write-only reads 0", 12'h004, 32'h0);
        rd_chk("R11 setmask reads 0", 12'h0C0, 32'h0);
    endtask

    task automatic t_level;
        wr(12'h40C, 32'h8000_0002);
        wr(12'h80C, 32'h1);
        wr(12'h0C0, 32'h8);
        @(negedge clk);
        irq_in[3] = 1'b1;
        @(negedge clk);
        chk("R4 R8 level pin", 32'(irq_pin), 32'h0004);
        chk("R10 code level", 32'(eic_code[3:0]), 32'h3);
        rd_chk("R4 pend word", 12'h040, 32'h8);
        @(negedge clk);
        irq_in[3] = 1'b0;
        @(negedge clk);
        chk("R4 level drop", 32'(irq_pin), 32'h0);
        wr(12'h140, 32'h0000_FFF7);
        @(negedge clk);
        chk("R4 active low", 32'(irq_pin), 32'h0004);
        wr(12'h140, 32'h0000_FFFF);
        @(negedge clk);
        chk("R4 active high again", 32'(irq_pin), 32'h0);
    endtask

    task automatic t_mask;
        @(negedge clk);
        irq_in[3] = 1'b1;
        @(negedge clk);
        chk("R7 visible", 32'(irq_pin), 32'h0004);
        wr(12'h100, 32'h8);
        @(negedge clk);
        chk("R6 clear mask pin", 32'(irq_pin), 32'h0);
        rd_chk("R6 mask cleared", 12'h080, 32'h0);
        wr(12'h0C0, 32'h0);
        rd_chk("R6 zero set no effect", 12'h080, 32'h0);
        wr(12'h0C0, 32'h8);
        @(negedge clk);
        chk("R6 set mask pin", 32'(irq_pin), 32'h0004);
        wr(12'h100, 32'h10);
        rd_chk("R6 other clear no effect", 12'h080, 32'h8);
        wr(12'h80C, 32'h2);
        @(negedge clk);
        chk("R7 core reroute", 32'(irq_pin), 32'h0400);
        irq_in[3] = 1'b0;
        wr(12'h80C, 32'h1);
        wr(12'h100, 32'h8);
        @(negedge clk);
        chk("R7 cleanup", 32'(irq_pin), 32'h0);
    endtask

    task automatic t_edge;
        wr(12'h180, 32'h20);
        wr(12'h414, 32'h8000_0004);
        wr(12'h814, 32'h1);
        wr(12'h0C0, 32'h20);
        @(negedge clk);
        chk("R5 idle", 32'(irq_pin), 32'h0);
        irq_in[5] = 1'b1;
        @(negedge clk);
        irq_in[5] = 1'b0;
        @(negedge clk);
        chk("R5 latched", 32'(irq_pin), 32'h0010);
        rd_chk("R5 pend word", 12'h040, 32'h20);
        wr(12'h040, 32'h20);
        @(negedge clk);
        chk("R5 w1c clears", 32'(irq_pin), 32'h0);
        irq_in[5] = 1'b1;
        @(negedge clk);
        irq_in[5] = 1'b0;
        @(negedge clk);
        chk("R5 relatched", 32'(irq_pin), 32'h0010);
        wr(12'h004, 32'h0000_0005);
        @(negedge clk);
        chk("R5 swclr clears edge", 32'(irq_pin), 32'h0);
    endtask

    task automatic t_swtrg;
        wr(12'h004, 32'h8000_0007);
        rd_chk("R3 raise", 12'h040, 32'h80);
        @(negedge clk);
        chk("R7 masked no pin", 32'(irq_pin), 32'h0);
        wr(12'h040, 32'h80);
        rd_chk("R5 w1c ignored on level", 12'h040, 32'h80);
        wr(12'h004, 32'h0000_0007);
        rd_chk("R3 drop", 12'h040, 32'h0);
    endtask

    task automatic t_nmi;
        wr(12'h424, 32'h4000_0001);
        wr(12'h824, 32'h3);
        wr(12'h0C0, 32'h200);
        wr(12'h004, 32'h8000_0009);
        @(negedge clk);
        chk("R9 nmi both cores", 32'(nmi), 32'h3);
        chk("R9 no pin", 32'(irq_pin), 32'h0);
        chk("R9 no code", 32'(eic_code), 32'h0);
        wr(12'h004, 32'h0000_0009);
        @(negedge clk);
        chk("R9 nmi drop", 32'(nmi), 32'h0);
    endtask

    task automatic t_eic;
        wr(12'h428, 32'h8000_0006);
        wr(12'h828, 32'h1);
        wr(12'h430, 32'h8000_0003);
        wr(12'h830, 32'h1);
        wr(12'h0C0, 32'h1400);
        wr(12'h004, 32'h8000_000C);
        @(negedge clk);
        chk("R10 single code", 32'(eic_code), 32'h04);
        chk("R8 pin3", 32'(irq_pin), 32'h0008);
        wr(12'h004, 32'h8000_000A);
        @(negedge clk);
        chk("R10 lowest index wins", 32'(eic_code), 32'h07);
        chk("R8 two pins", 32'(irq_pin), 32'h0048);
        wr(12'h004, 32'h0000_000A);
        @(negedge clk);
        chk("R10 back to higher", 32'(eic_code), 32'h04);
        wr(12'h004, 32'h0000_000C);
        @(negedge clk);
        chk("R10 none zero", 32'(eic_code), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_port();
        t_level();
        t_mask();
        t_edge();
        t_swtrg();
        t_nmi();
        t_eic();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule